// File: doc/BRIEF.md
# Conditional Gateway Match Unit

This block sits in front of a match table's result path and decides, once per cycle, whether a small set of programmable conditions should take over that path. A search word is compared against a handful of ternary rows, each holding a value and a care mask. The lowest-numbered row that hits is the winner. If no programmed row hits, a dedicated fallback row wins in its place. Every row, the fallback row included, carries an inhibit flag, a payload and a next-table pointer.

When the winning row has inhibit set, the block replaces the incoming match result with that row's payload and takes the next-table pointer from that row's lookup entry. The payload is never used as the pointer. When inhibit is clear, the incoming result bus, hit flag and next-table pointer pass through untouched, so the attached table's own hit or miss path decides what runs next. A table that holds no match data always reports a miss. It can reach the hit path only through an inhibited programmed row, whose payload (for example 1) then serves as a per-flow enable bit.

The per-cycle decision is an enumerated state held in one register. A separate output process drives the ports from it. The five states are:
- `GW_BYPASS`: enable is low.
- `GW_ROW_THRU`: a programmed row hit with inhibit clear.
- `GW_ROW_OVR`: a programmed row hit with inhibit set.
- `GW_MISS_THRU`: no programmed row hit and the fallback row's inhibit is clear.
- `GW_MISS_OVR`: no programmed row hit and the fallback row's inhibit is set.

Every state can follow every other state, and the choice is made afresh each cycle. Enable low selects `GW_BYPASS`. Otherwise, any programmed hit selects one of the two row states, and no programmed hit selects one of the two miss states. In each case the winning row's inhibit flag picks between the two.

Top module: `gw_match_unit`

## Requirements
- R1: A programmed row r hits when its valid bit is set and `((key ^ value) & mask) == 0`. Bits where the mask is 0 are ignored.
- R2: When several programmed rows hit, the lowest-numbered one wins. `gw_row_idx` reports its number and `gw_row_hit` is 1.
- R3: When no programmed row hits and enable is high, the fallback row wins. `gw_row_idx` equals ROWS (4 by default) and `gw_row_hit` is 0.
- R4: When the winning programmed row has inhibit set, the outputs are as follows:
  - `mr_out_bus` carries the row's payload.
  - `mr_out_hit` is 1, even when `mr_in_hit` is 0.
  - `mr_out_next` carries the row's next-table entry.
  - `gw_override` is 1.
- R5: When the winning programmed row has inhibit clear, `mr_out_bus`, `mr_out_hit` and `mr_out_next` equal the incoming bus, hit and next values, and `gw_override` is 0.
- R6: When the fallback row wins, the outputs depend on its inhibit flag:
  - Inhibit set: the bus carries its payload, `mr_out_hit` is 0, `mr_out_next` carries its next entry, and `gw_override` is 1.
  - Inhibit clear: the incoming values pass through.
- R7: With `gw_en` low, the outputs are as follows:
  - The incoming bus, hit and next values pass through.
  - `gw_row_hit` and `gw_override` are 0.
  - `gw_row_idx` is 0.
- R8: The configuration address is `{row[2:0], field[1:0]}`. The fields are:
  - 0: value.
  - 1: mask.
  - 2: control, with payload in bits [15:0], next-table entry in bits [23:16], inhibit in bit 24 and valid in bit 25 (the valid bit is unused for the fallback row).

  The following writes change nothing: field 3, rows above 4, and value or mask writes to row 4. A write takes effect for searches presented from the next cycle on.
- R9: The outputs reflect the inputs sampled at the previous rising edge. After reset all outputs are 0, all rows are invalid, and all inhibit flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gw_en | input | 1 | Gateway enable; low forces pass-through |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address {row, field} |
| cfg_wdata | input | 44 | Configuration write data |
| search_key | input | 44 | Search word compared against the rows |
| mr_in_bus | input | 16 | Incoming match result bus |
| mr_in_hit | input | 1 | Incoming match hit flag |
| mr_in_next | input | 8 | Incoming next-table pointer |
| mr_out_bus | output | 16 | Outgoing match result bus |
| mr_out_hit | output | 1 | Outgoing hit flag |
| mr_out_next | output | 8 | Outgoing next-table pointer |
| gw_row_hit | output | 1 | A programmed row won |
| gw_row_idx | output | 3 | Winning row number; ROWS for the fallback row |
| gw_override | output | 1 | The result bus was replaced by a payload |

## Verification
Some properties are checked on every cycle:
- At most one row is granted.
- No row below the granted one hits.
- Every non-override cycle passes the previous cycle's incoming bus unchanged.
- An override never follows a disabled cycle.
- A programmed-row override always raises the hit flag.
- A fallback-row win reports index ROWS.
- Writes to the unused field disturb no control state.

The bench's sweeps are the only place where the following are shown:
- The ternary compare is correct over masked and unmasked bits, including the top key bit.
- The correct payload and lookup entry are chosen for each winner under every inhibit pattern.
- Out-of-range configuration writes are ignored.
- Results appear exactly one cycle after the search.

// File: rtl/gw_pkg.sv
package gw_pkg;
    typedef enum logic [2:0] {
        GW_BYPASS    = 3'd0,
        GW_ROW_THRU  = 3'd1,
        GW_ROW_OVR   = 3'd2,
        GW_MISS_THRU = 3'd3,
        GW_MISS_OVR  = 3'd4
    } gw_dec_e;

    localparam logic [1:0] FLD_VALUE = 2'd0;
    localparam logic [1:0] FLD_MASK  = 2'd1;
    localparam logic [1:0] FLD_CTRL  = 2'd2;
endpackage

// File: rtl/gw_row_cmp.sv
module gw_row_cmp #(
    parameter int KEY_W = 44
) (
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] value,
    input  logic [KEY_W-1:0] mask,
    input  logic             valid,
    output logic             hit
);
    // R1: masked ternary compare
    assign hit = valid && (((key ^ value) & mask) == '0);
endmodule

// File: rtl/gw_prio_sel.sv
module gw_prio_sel #(
    parameter int ROWS = 4,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] hit,
    output logic            any,
    output logic [IW-1:0]   idx
);
    logic [ROWS-1:0] grant;

    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = IW'(ROWS);
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
                idx      = IW'(i);
            end
        end
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2 and R3: nothing below the grant hits; with no grant nothing hits
    p_no_lower_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant - ROWS'(1)) & hit) == '0);
endmodule

// File: rtl/gw_cfg_regs.sv
module gw_cfg_regs #(
    parameter int ROWS  = 4,
    parameter int KEY_W = 44,
    parameter int BUS_W = 16,
    parameter int NT_W  = 8,
    parameter int IW    = 3,
    parameter int DW    = 44
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [IW+1:0]              cfg_addr,
    input  logic [DW-1:0]              cfg_wdata,
    output logic [ROWS-1:0][KEY_W-1:0] row_val,
    output logic [ROWS-1:0][KEY_W-1:0] row_msk,
    output logic [ROWS-1:0]            row_vld,
    output logic [ROWS:0]              row_inh,
    output logic [ROWS:0][BUS_W-1:0]   row_pay,
    output logic [ROWS:0][NT_W-1:0]    row_nt
);
    import gw_pkg::*;

    localparam int NT_LSB  = BUS_W;
    localparam int INH_BIT = BUS_W + NT_W;
    localparam int VLD_BIT = BUS_W + NT_W + 1;

    logic [IW-1:0] wr_row;
    logic [1:0]    wr_fld;
    assign wr_row = cfg_addr[IW+1:2];
    assign wr_fld = cfg_addr[1:0];

    for (genvar r = 0; r <= ROWS; r++) begin : g_row
        logic             sel;
        logic             inh_q;
        logic [BUS_W-1:0] pay_q;
        logic [NT_W-1:0]  nt_q;

        assign sel = cfg_we && (wr_row == IW'(r));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inh_q <= 1'b0;
                pay_q <= '0;
                nt_q  <= '0;
            end else if (sel && wr_fld == FLD_CTRL) begin
                inh_q <= cfg_wdata[INH_BIT];
                pay_q <= cfg_wdata[BUS_W-1:0];
                nt_q  <= cfg_wdata[NT_LSB +: NT_W];
            end
        end

        assign row_inh[r] = inh_q;
        assign row_pay[r] = pay_q;
        assign row_nt[r]  = nt_q;

        if (r < ROWS) begin : g_prog
            logic [KEY_W-1:0] val_q;
            logic [KEY_W-1:0] msk_q;
            logic             vld_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                    msk_q <= '0;
                    vld_q <= 1'b0;
                end else if (sel) begin
                    if (wr_fld == FLD_VALUE) val_q <= cfg_wdata[KEY_W-1:0];
                    if (wr_fld == FLD_MASK)  msk_q <= cfg_wdata[KEY_W-1:0];
                    if (wr_fld == FLD_CTRL)  vld_q <= cfg_wdata[VLD_BIT];
                end
            end

            assign row_val[r] = val_q;
            assign row_msk[r] = msk_q;
            assign row_vld[r] = vld_q;
        end
    end

    // R8: the unused field leaves control state alone
    p_unused_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_fld == 2'd3) |=> ($stable(row_inh) && $stable(row_pay) && $stable(row_nt)));
endmodule

// File: rtl/gw_match_unit.sv
module gw_match_unit #(
    parameter int ROWS  = 4,
    parameter int KEY_W = 44,
    parameter int BUS_W = 16,
    parameter int NT_W  = 8,
    localparam int IW     = $clog2(ROWS + 1),
    localparam int AW     = IW + 2,
    localparam int CTRL_W = BUS_W + NT_W + 2,
    localparam int DW     = (KEY_W > CTRL_W) ? KEY_W : CTRL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gw_en,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic [KEY_W-1:0] search_key,
    input  logic [BUS_W-1:0] mr_in_bus,
    input  logic             mr_in_hit,
    input  logic [NT_W-1:0]  mr_in_next,
    output logic [BUS_W-1:0] mr_out_bus,
    output logic             mr_out_hit,
    output logic [NT_W-1:0]  mr_out_next,
    output logic             gw_row_hit,
    output logic [IW-1:0]    gw_row_idx,
    output logic             gw_override
);
    import gw_pkg::*;

    logic [ROWS-1:0][KEY_W-1:0] row_val;
    logic [ROWS-1:0][KEY_W-1:0] row_msk;
    logic [ROWS-1:0]            row_vld;
    logic [ROWS:0]              row_inh;
    logic [ROWS:0][BUS_W-1:0]   row_pay;
    logic [ROWS:0][NT_W-1:0]    row_nt;
    logic [ROWS-1:0]            row_hit;
    logic                       any_hit;
    logic [IW-1:0]              win_idx;

    gw_cfg_regs #(
        .ROWS(ROWS), .KEY_W(KEY_W), .BUS_W(BUS_W), .NT_W(NT_W), .IW(IW), .DW(DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .row_val(row_val), .row_msk(row_msk),
        .row_vld(row_vld), .row_inh(row_inh), .row_pay(row_pay), .row_nt(row_nt)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_cmp
        gw_row_cmp #(.KEY_W(KEY_W)) u_cmp (
            .key(search_key), .value(row_val[r]), .mask(row_msk[r]),
            .valid(row_vld[r]), .hit(row_hit[r])
        );
    end

    gw_prio_sel #(.ROWS(ROWS), .IW(IW)) u_prio (
        .clk(clk), .rst_n(rst_n), .hit(row_hit), .any(any_hit), .idx(win_idx)
    );

    gw_dec_e          dec_d, dec_q;
    logic [IW-1:0]    idx_q;
    logic [BUS_W-1:0] pass_bus_q, pay_q;
    logic             pass_hit_q;
    logic [NT_W-1:0]  pass_nt_q, lut_q;
    logic             seen_q;

    always_comb begin
        dec_d = GW_BYPASS;
        if (gw_en) begin
            if (any_hit) dec_d = row_inh[win_idx] ? GW_ROW_OVR : GW_ROW_THRU;
            else         dec_d = row_inh[win_idx] ? GW_MISS_OVR : GW_MISS_THRU;
        end
    end

    // decision register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q      <= GW_BYPASS;
            idx_q      <= '0;
            pass_bus_q <= '0;
            pass_hit_q <= 1'b0;
            pass_nt_q  <= '0;
            pay_q      <= '0;
            lut_q      <= '0;
            seen_q     <= 1'b0;
        end else begin
            dec_q      <= dec_d;
            idx_q      <= win_idx;
            pass_bus_q <= mr_in_bus;
            pass_hit_q <= mr_in_hit;
            pass_nt_q  <= mr_in_next;
            pay_q      <= row_pay[win_idx];
            lut_q      <= row_nt[win_idx];
            seen_q     <= 1'b1;
        end
    end

    // output process
    always_comb begin
        mr_out_bus  = pass_bus_q;
        mr_out_hit  = pass_hit_q;
        mr_out_next = pass_nt_q;
        gw_row_hit  = 1'b0;
        gw_row_idx  = idx_q;
        gw_override = 1'b0;
        unique case (dec_q)
            GW_BYPASS:    gw_row_idx = '0;
            GW_ROW_THRU:  gw_row_hit = 1'b1;
            GW_ROW_OVR: begin
                gw_row_hit  = 1'b1;
                gw_override = 1'b1;
                mr_out_bus  = pay_q;
                mr_out_hit  = 1'b1;
                mr_out_next = lut_q;
            end
            GW_MISS_THRU: gw_row_idx = idx_q;
            GW_MISS_OVR: begin
                gw_override = 1'b1;
                mr_out_bus  = pay_q;
                mr_out_hit  = 1'b0;
                mr_out_next = lut_q;
            end
            default:      gw_row_idx = '0;
        endcase
    end

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(gw_en)) |-> (!gw_row_hit && !gw_override && gw_row_idx == '0));

    p_pass_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !gw_override) |-> (mr_out_bus == $past(mr_in_bus) && mr_out_next == $past(mr_in_next)));

    p_override_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && gw_override) |-> $past(gw_en));

    p_override_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_override && gw_row_hit) |-> mr_out_hit);

    p_miss_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(gw_en) && !gw_row_hit) |-> (gw_row_idx == IW'(ROWS)));

    p_row_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gw_row_hit |-> (gw_row_idx < IW'(ROWS)));
endmodule

// File: tb/tb_gw_match_unit.sv
`timescale 1ns/1ps
module tb_gw_match_unit;
    localparam int ROWS = 4, KEY_W = 44, BUS_W = 16, NT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gw_en = 1'b0;
    logic             cfg_we = 1'b0;
    logic [4:0]       cfg_addr = '0;
    logic [43:0]      cfg_wdata = '0;
    logic [KEY_W-1:0] search_key = '0;
    logic [BUS_W-1:0] mr_in_bus = '0;
    logic             mr_in_hit = 1'b0;
    logic [NT_W-1:0]  mr_in_next = '0;
    logic [BUS_W-1:0] mr_out_bus;
    logic             mr_out_hit;
    logic [NT_W-1:0]  mr_out_next;
    logic             gw_row_hit;
    logic [2:0]       gw_row_idx;
    logic             gw_override;

    gw_match_unit dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;

    logic [KEY_W-1:0] m_val [ROWS];
    logic [KEY_W-1:0] m_msk [ROWS];
    logic             m_vld [ROWS];
    logic             m_inh [ROWS+1];
    logic [BUS_W-1:0] m_pay [ROWS+1];
    logic [NT_W-1:0]  m_nt  [ROWS+1];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [43:0] ctrl_word(logic vld, logic inh, logic [7:0] nt, logic [15:0] pay);
        return {18'd0, vld, inh, nt, pay};
    endfunction

    task automatic cfg_wr(int row, int fld, logic [43:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {row[2:0], fld[1:0]};
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (row < ROWS && fld == 0) m_val[row] = data;
        if (row < ROWS && fld == 1) m_msk[row] = data;
        if (row <= ROWS && fld == 2) begin
            m_pay[row] = data[15:0];
            m_nt[row]  = data[23:16];
            m_inh[row] = data[24];
            if (row < ROWS) m_vld[row] = data[25];
        end
    endtask

    task automatic apply(string pfx, logic en, logic [KEY_W-1:0] key,
                         logic [BUS_W-1:0] ib, logic ih, logic [NT_W-1:0] in_nt);
        int win = ROWS;
        logic [BUS_W-1:0] e_bus;
        logic e_hit, e_gh, e_ov;
        logic [NT_W-1:0] e_nt;
        logic [2:0] e_idx;
        string tag;
        @(negedge clk);
        gw_en = en; search_key = key; mr_in_bus = ib; mr_in_hit = ih; mr_in_next = in_nt;
        for (int i = ROWS - 1; i >= 0; i--)
            if (m_vld[i] && ((key ^ m_val[i]) & m_msk[i]) == '0) win = i;
        e_bus = ib; e_hit = ih; e_nt = in_nt; e_gh = 1'b0; e_ov = 1'b0; e_idx = 3'(win);
        if (!en) begin
            e_idx = 3'd0; tag = "R7";
        end else begin
            e_gh = (win < ROWS);
            tag = (win < ROWS) ? (m_inh[win] ? "R4" : "R5") : "R6";
            if (m_inh[win]) begin
                e_ov = 1'b1; e_bus = m_pay[win]; e_nt = m_nt[win]; e_hit = (win < ROWS);
            end
        end
        @(posedge clk);
        #1;
        chk({pfx, tag, " bus"}, 64'(mr_out_bus), 64'(e_bus));
        chk({pfx, tag, " hit"}, 64'(mr_out_hit), 64'(e_hit));
        chk({pfx, tag, " next"}, 64'(mr_out_next), 64'(e_nt));
        chk({pfx, tag, " override"}, 64'(gw_override), 64'(e_ov));
        chk({pfx, (!en) ? "R7" : (win < ROWS) ? "R1 R2" : "R3", " row_idx"}, 64'(gw_row_idx), 64'(e_idx));
        chk({pfx, (!en) ? "R7" : (win < ROWS) ? "R1 R2" : "R3", " row_hit"}, 64'(gw_row_hit), 64'(e_gh));
    endtask

    task automatic sweep(string pfx);
        for (int hi = 0; hi < 2; hi++)
            for (int nib = 0; nib < 16; nib++)
                apply(pfx, nib != 5, {hi[0], 39'h5A5A5A5A5A, nib[3:0]},
                      16'(nib * 37 + hi * 1000), nib[0] ^ hi[0], 8'(nib * 5 + hi));
    endtask

    task automatic load_ctrl(int p, logic row2_vld);
        for (int r = 0; r <= ROWS; r++)
            cfg_wr(r, 2, ctrl_word(r != 2 || row2_vld, p[r], 8'(8'h10 + r + p),
                                   (r == 1) ? 16'h0001 : 16'(16'h100 * r + p)));
    endtask

    bit done = 1'b0;

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            m_val[r] = '0; m_msk[r] = '0; m_vld[r] = 1'b0;
        end
        for (int r = 0; r <= ROWS; r++) begin
            m_inh[r] = 1'b0; m_pay[r] = '0; m_nt[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset bus", 64'(mr_out_bus), 64'd0);
        chk("R9 reset flags", {61'd0, mr_out_hit, gw_row_hit, gw_override}, 64'd0);
        chk("R9 reset idx", 64'(gw_row_idx), 64'd0);
        // R9 latency: output unchanged before the edge, updated after it
        gw_en = 1'b0; mr_in_bus = 16'hBEEF;
        #1;
        chk("R9 before edge", 64'(mr_out_bus), 64'd0);
        @(posedge clk); #1;
        chk("R9 after edge", 64'(mr_out_bus), 64'hBEEF);
        // R3/R6 with reset configuration: fallback row, pass-through
        apply("", 1'b1, 44'h123, 16'h4444, 1'b1, 8'h22);

        // rows: 0 exact low nibble 3, 1 odd keys, 2 catch-all, 3 bit3 and bit43 set
        cfg_wr(0, 0, 44'h3);            cfg_wr(0, 1, 44'hF);
        cfg_wr(1, 0, 44'h1);            cfg_wr(1, 1, 44'h1);
        cfg_wr(2, 0, 44'hFFF);          cfg_wr(2, 1, 44'h0);
        cfg_wr(3, 0, {1'b1, 43'h8});    cfg_wr(3, 1, {1'b1, 43'h8});

        for (int p = 0; p < 32; p++) begin
            load_ctrl(p, 1'b0);
            sweep("");
        end
        for (int p = 0; p < 32; p += 5) begin
            load_ctrl(p, 1'b1);
            sweep("");
        end

        // R8: ignored writes
        load_ctrl(31, 1'b0);
        cfg_wr(0, 3, 44'hFFFFFFFFFFF);
        cfg_wr(4, 0, 44'h0);
        cfg_wr(4, 1, 44'hFFFFFFFFFFF);
        for (int r = 5; r < 8; r++) begin
            cfg_wr(r, 2, ctrl_word(1'b1, 1'b0, 8'hEE, 16'hDEAD));
            cfg_wr(r, 0, 44'h0);
        end
        sweep("R8 ");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule